// File: doc/BRIEF.md
# Prescaled Match Timer

A 16-bit up-counting timer clocked from the peripheral clock through a programmable 16-bit prescaler. A prescale count runs from zero up to a programmed limit. On the clock where it sits at that limit, the timer advances by one and the prescale count returns to zero. The timer therefore steps once every limit+1 clocks.

Four compare channels each hold a 16-bit value. A channel raises a sticky flag on the clock at which a counting step lands the timer on that value. One capture input is synchronised into the clock domain and checked for a rising edge. On that edge the current timer value is stored and a capture flag is raised. Software controls the block through a synchronous word-addressed register port with a combinational read. A single interrupt line is high while any flag is set.

Top module: `prescaled_match_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low. Software-visible state is released two clocks after `rst_n` rises.
- R2: While running, the prescale count steps 0,1,…,P and then returns to 0, where P is the prescale limit at word 3 (byte 0x0C). The timer increments on each clock where the prescale count equals P, so it advances every P+1 clocks.
- R3: Control bit 1 (word 1, byte 0x04) is a counter clear. While it is set, each clock forces both the timer and the prescale count to 0, and this overrides software loads. Counting resumes only after the bit is written back to 0.
- R4: Control bit 0 is the run enable. While it is 0 and no clear or load is active, the timer and the prescale count hold their values.
- R5: The timer wraps from 0xFFFF to 0x0000, and the wrap by itself sets no flag.
- R6: Compare values sit at words 6–9 (bytes 0x18–0x24) for channels 0–3. Flag bit i is set on the clock where a counting step makes the timer equal compare value i. A compare value of 0 therefore flags a wrap.
- R7: The flag register is at word 0 (byte 0x00), with bits 0–3 for compare channels 0–3 and bit 4 for capture. Writing 1 to a bit clears it and writing 0 leaves it. An event in the same clock as its clear leaves the flag set.
- R8: `cap_in` passes through two synchroniser stages. On a detected rising edge, the capture register (word 11, byte 0x2C) takes the timer value and flag bit 4 sets. A level held high causes no further capture.
- R9: `irq` is the OR of the five flags.
- R10: Register bits above each field read 0. Unmapped words 5, 10 and 12–15 read 0. Software may load the timer (word 2, byte 0x08) and the prescale count (word 4, byte 0x10) directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| cap_in | input | 1 | Capture trigger input (asynchronous) |
| irq | output | 1 | OR of all flags |

## Verification
The bench checks the prescale boundary, where a count that reloaded one clock early or late would shift every timer step and disagree with the reference model. It holds the clear bit while also loading the timer, so a design that let the load win would read nonzero. It arranges for a compare hit to land on the same clock as a write that clears that flag, so a design that gave the clear priority would lose the event. It also runs the timer through 0xFFFF, where a design that flagged the wrap, or missed a compare value of zero, shows up in the flag register. Capture is tested with the counter frozen, so the stored value is known exactly, and with a held-high level that must not recapture.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  // Word addresses of the register file; byte offset is four times these.
  localparam int ADR_FLAGS = 0;
  localparam int ADR_CTRL  = 1;
  localparam int ADR_TC    = 2;
  localparam int ADR_PR    = 3;
  localparam int ADR_PC    = 4;
  localparam int ADR_MR0   = 6;
  localparam int ADR_CAP   = 11;

  // Control register bit positions.
  localparam int CTRL_RUN = 0;
  localparam int CTRL_CLR = 1;
endpackage

// File: rtl/pmt_rst_sync.sv
module pmt_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) stage_q <= 2'b00;
    else              stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/pmt_count_core.sv
module pmt_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  input  logic             tc_ld,
  input  logic             pc_ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] tc,
  output logic [CNT_W-1:0] pc,
  output logic             step
);
  logic [CNT_W-1:0] tc_q, tc_d, pc_q, pc_d;
  logic             at_limit;

  assign at_limit = (pc_q == limit);
  assign step     = run && !clr && !tc_ld && at_limit;

  always_comb begin
    tc_d = tc_q;
    pc_d = pc_q;
    if (clr) begin
      tc_d = '0;
      pc_d = '0;
    end else begin
      if (tc_ld)                tc_d = ld_val;
      else if (run && at_limit) tc_d = tc_q + 1'b1;
      if (pc_ld)                pc_d = ld_val;
      else if (run)             pc_d = at_limit ? '0 : pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
      pc_q <= '0;
    end else begin
      tc_q <= tc_d;
      pc_q <= pc_d;
    end
  end

  assign tc = tc_q;
  assign pc = pc_q;

  assert_tick_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !tc_ld && pc_q == limit) |=> (tc_q == CNT_W'($past(tc_q) + 1'b1)));

  assert_tick_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !tc_ld && pc_q != limit) |=> $stable(tc_q));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tc_q == '0 && pc_q == '0));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !tc_ld && !pc_ld) |=> ($stable(tc_q) && $stable(pc_q)));
endmodule

// File: rtl/pmt_capture.sv
module pmt_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic [CNT_W-1:0] tc,
  output logic [CNT_W-1:0] cap_val,
  output logic             hit
);
  logic [2:0]       sync_q, sync_d;
  logic [CNT_W-1:0] cap_q, cap_d;

  assign hit = sync_q[1] && !sync_q[2];

  always_comb begin
    sync_d = {sync_q[1:0], cap_in};
    cap_d  = hit ? tc : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cap_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cap_q  <= cap_d;
    end
  end

  assign cap_val = cap_q;

  assert_capture_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cap_q == $past(tc)));

  assert_capture_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(cap_q));
endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer #(
  parameter int CNT_W     = 16,
  parameter int NUM_MATCH = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              cap_in,
  output logic              irq
);
  import pmt_pkg::*;

  localparam int NFLAG   = NUM_MATCH + 1;
  localparam int CAP_BIT = NUM_MATCH;

  logic             rst_s;
  logic             run_q, run_d, clr_q, clr_d;
  logic [CNT_W-1:0] pr_q, pr_d;
  logic [CNT_W-1:0] mr_q [NUM_MATCH];
  logic [CNT_W-1:0] mr_d [NUM_MATCH];
  logic [NFLAG-1:0] flags_q, flags_d, evt, clr_mask;
  logic [CNT_W-1:0] tc, pc, cap_val, tc_next;
  logic             step, cap_hit;
  logic             wr_flags, wr_ctrl, wr_tc, wr_pr, wr_pc;
  logic [CNT_W-1:0] wval;
  logic             unused_hi;

  assign wval      = wdata[CNT_W-1:0];
  assign unused_hi = ^wdata[DATA_W-1:CNT_W];

  assign wr_flags = wr_en && (addr == ADDR_W'(ADR_FLAGS));
  assign wr_ctrl  = wr_en && (addr == ADDR_W'(ADR_CTRL));
  assign wr_tc    = wr_en && (addr == ADDR_W'(ADR_TC));
  assign wr_pr    = wr_en && (addr == ADDR_W'(ADR_PR));
  assign wr_pc    = wr_en && (addr == ADDR_W'(ADR_PC));

  pmt_rst_sync u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_s)
  );

  pmt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk   (clk),
    .rst_n (rst_s),
    .run   (run_q),
    .clr   (clr_q),
    .limit (pr_q),
    .tc_ld (wr_tc),
    .pc_ld (wr_pc),
    .ld_val(wval),
    .tc    (tc),
    .pc    (pc),
    .step  (step)
  );

  pmt_capture #(.CNT_W(CNT_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_s),
    .cap_in (cap_in),
    .tc     (tc),
    .cap_val(cap_val),
    .hit    (cap_hit)
  );

  assign tc_next = tc + 1'b1;

  // Compare channels: event when a counting step lands on the compare value.
  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    assign evt[i]  = step && (tc_next == mr_q[i]);
    assign mr_d[i] = (wr_en && addr == ADDR_W'(ADR_MR0 + i)) ? wval : mr_q[i];

    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) mr_q[i] <= '0;
      else        mr_q[i] <= mr_d[i];
    end

    assert_match_flag_R6: assert property (@(posedge clk) disable iff (!rst_s)
      $rose(flags_q[i]) |-> (tc == $past(mr_q[i])));
  end

  assign evt[CAP_BIT] = cap_hit;
  assign clr_mask     = wr_flags ? wdata[NFLAG-1:0] : '0;

  always_comb begin
    flags_d = (flags_q & ~clr_mask) | evt;
    run_d   = wr_ctrl ? wdata[CTRL_RUN] : run_q;
    clr_d   = wr_ctrl ? wdata[CTRL_CLR] : clr_q;
    pr_d    = wr_pr   ? wval            : pr_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      flags_q <= '0;
      run_q   <= 1'b0;
      clr_q   <= 1'b0;
      pr_q    <= '0;
    end else begin
      flags_q <= flags_d;
      run_q   <= run_d;
      clr_q   <= clr_d;
      pr_q    <= pr_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADR_FLAGS)) rdata = DATA_W'(flags_q);
    if (addr == ADDR_W'(ADR_CTRL))  rdata = DATA_W'({clr_q, run_q});
    if (addr == ADDR_W'(ADR_TC))    rdata = DATA_W'(tc);
    if (addr == ADDR_W'(ADR_PR))    rdata = DATA_W'(pr_q);
    if (addr == ADDR_W'(ADR_PC))    rdata = DATA_W'(pc);
    if (addr == ADDR_W'(ADR_CAP))   rdata = DATA_W'(cap_val);
    for (int i = 0; i < NUM_MATCH; i++) begin
      if (addr == ADDR_W'(ADR_MR0 + i)) rdata = DATA_W'(mr_q[i]);
    end
  end

  assign irq = |flags_q;

  for (genvar f = 0; f < NFLAG; f++) begin : g_sticky
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_s)
      (flags_q[f] && !(wr_flags && wdata[f])) |=> flags_q[f]);
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_s)
      evt[f] |=> flags_q[f]);
  end

  assert_capture_flag_R8: assert property (@(posedge clk) disable iff (!rst_s)
    cap_hit |=> flags_q[CAP_BIT]);

  assert_wrap_silent_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (step && tc == '1 && !evt[0] && !evt[1] && !evt[2] && !evt[3] && !cap_hit
     && !flags_q[0] && !flags_q[1] && !flags_q[2] && !flags_q[3] && !flags_q[CAP_BIT])
    |=> !irq);
endmodule

// File: tb/prescaled_match_timer_test.sv
`timescale 1ns/1ps
module prescaled_match_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = 32'd0;
  logic        cap_in = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  prescaled_match_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference state
  logic [15:0] m_pc, m_tc, m_pr, m_cap;
  logic [15:0] m_mr [4];
  logic        m_en, m_clr;
  logic [4:0]  m_flags;
  logic        s1, s2, s3;
  int          m_rcnt;
  // scratch for one model step
  logic [15:0] n_tc, n_pc, tc_plus;
  logic [4:0]  ev, cmask;
  bit          inc, rise, w;

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0:  return {27'd0, m_flags};
      4'd1:  return {30'd0, m_clr, m_en};
      4'd2:  return {16'd0, m_tc};
      4'd3:  return {16'd0, m_pr};
      4'd4:  return {16'd0, m_pc};
      4'd6:  return {16'd0, m_mr[0]};
      4'd7:  return {16'd0, m_mr[1]};
      4'd8:  return {16'd0, m_mr[2]};
      4'd9:  return {16'd0, m_mr[3]};
      4'd11: return {16'd0, m_cap};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n || m_rcnt < 2) begin
      if (!rst_n) m_rcnt = 0; else m_rcnt = m_rcnt + 1;
      m_pc = 0; m_tc = 0; m_pr = 0; m_cap = 0;
      for (int i = 0; i < 4; i++) m_mr[i] = 0;
      m_en = 0; m_clr = 0; m_flags = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      w       = wr_en;
      inc     = m_en && !m_clr && !(w && addr == 4'd2) && (m_pc == m_pr);
      tc_plus = m_tc + 16'd1;
      ev      = 5'd0;
      for (int i = 0; i < 4; i++) if (inc && tc_plus == m_mr[i]) ev[i] = 1'b1;
      rise = s2 && !s3;
      if (rise) begin ev[4] = 1'b1; m_cap = m_tc; end
      n_tc = m_tc; n_pc = m_pc;
      if (m_clr) begin n_tc = 0; n_pc = 0; end
      else begin
        if (w && addr == 4'd2) n_tc = wdata[15:0];
        else if (m_en && m_pc == m_pr) n_tc = tc_plus;
        if (w && addr == 4'd4) n_pc = wdata[15:0];
        else if (m_en) n_pc = (m_pc == m_pr) ? 16'd0 : m_pc + 16'd1;
      end
      cmask   = (w && addr == 4'd0) ? wdata[4:0] : 5'd0;
      m_flags = (m_flags & ~cmask) | ev;
      if (w && addr == 4'd1) begin m_en = wdata[0]; m_clr = wdata[1]; end
      if (w && addr == 4'd3) m_pr = wdata[15:0];
      for (int i = 0; i < 4; i++) if (w && addr == 4'(6 + i)) m_mr[i] = wdata[15:0];
      m_tc = n_tc; m_pc = n_pc;
      s3 = s2; s2 = s1; s1 = cap_in;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Every-clock comparison against the reference model
  always @(negedge clk) begin
    if (started && !done) begin
      chk(rdata == m_read(addr), cur_req, "model rdata", rdata, m_read(addr));
      chk(irq == (m_flags != 0), "R9", "model irq", {31'd0, irq}, {31'd0, m_flags != 0});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      chk(1'b0, "watchdog", "run hung", cyc, 20000);
      finish_run();
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    chk(rdata == exp, req, "directed read", rdata, exp);
  endtask

  logic [31:0] snap;

  initial begin
    repeat (3) @(posedge clk);
    started = 1;
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values
    cur_req = "R1";
    for (int a = 0; a < 12; a++) rd_check(4'(a), 32'd0, "R1");
    @(negedge clk);
    chk(irq == 1'b0, "R1", "irq after reset", {31'd0, irq}, 32'd0);

    // R2: limit 2 => one step per 3 clocks
    cur_req = "R2";
    wr(4'd3, 32'd2);
    wr(4'd1, 32'd1);
    addr = 4'd2;
    repeat (9) @(posedge clk);
    @(negedge clk);
    chk(rdata == 32'd3, "R2", "timer after 9 clocks at limit 2", rdata, 32'd3);
    repeat (7) @(posedge clk);

    // R4: disable freezes
    cur_req = "R4";
    wr(4'd1, 32'd0);
    addr = 4'd2;
    @(negedge clk); snap = rdata;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(rdata == snap, "R4", "timer frozen", rdata, snap);

    // R3: clear bit holds zero and beats a load
    cur_req = "R3";
    wr(4'd1, 32'd3);
    addr = 4'd2;
    @(posedge clk); @(negedge clk);
    chk(rdata == 32'd0, "R3", "timer cleared", rdata, 32'd0);
    wr(4'd2, 32'h55);
    rd_check(4'd2, 32'd0, "R3");
    rd_check(4'd4, 32'd0, "R3");
    wr(4'd1, 32'd1);
    repeat (8) @(posedge clk);

    // R10: direct loads of timer and prescale count
    cur_req = "R10";
    wr(4'd1, 32'd0);
    wr(4'd2, 32'h0100);
    wr(4'd4, 32'h0001);
    rd_check(4'd2, 32'h0100, "R10");
    rd_check(4'd4, 32'h0001, "R10");

    // R5: wrap sets no flag
    cur_req = "R5";
    wr(4'd0, 32'h1F);
    for (int i = 0; i < 4; i++) wr(4'(6 + i), 32'h1234);
    wr(4'd3, 32'd0);
    wr(4'd4, 32'd0);
    wr(4'd2, 32'hFFFD);
    wr(4'd1, 32'd1);
    repeat (6) @(posedge clk);
    rd_check(4'd0, 32'd0, "R5");
    addr = 4'd2; @(negedge clk);
    chk(rdata < 32'h10, "R5", "timer wrapped", rdata, 32'h4);

    // R6: compare hit and wrap detection via compare 0
    cur_req = "R6";
    wr(4'd1, 32'd0);
    wr(4'd3, 32'd1);
    wr(4'd4, 32'd0);
    wr(4'd2, 32'd0);
    wr(4'd7, 32'd5);
    wr(4'd1, 32'd1);
    repeat (16) @(posedge clk);
    wr(4'd1, 32'd0);
    rd_check(4'd0, 32'h2, "R6");
    @(negedge clk);
    chk(irq == 1'b1, "R9", "irq with flag", {31'd0, irq}, 32'd1);
    wr(4'd0, 32'h1F);
    wr(4'd6, 32'd0);
    wr(4'd3, 32'd0);
    wr(4'd2, 32'hFFFE);
    wr(4'd1, 32'd1);
    repeat (2) @(posedge clk);
    wr(4'd1, 32'd0);
    rd_check(4'd0, 32'h1, "R6");

    // R7: write-one-clear, write-zero no effect, event beats clear
    cur_req = "R7";
    wr(4'd0, 32'h1F);
    rd_check(4'd0, 32'd0, "R7");
    @(negedge clk);
    chk(irq == 1'b0, "R9", "irq cleared", {31'd0, irq}, 32'd0);
    wr(4'd8, 32'h13);
    wr(4'd2, 32'h0100);
    wr(4'd1, 32'd1);
    wr(4'd2, 32'h10);
    @(posedge clk);
    wr(4'd0, 32'h4);
    wr(4'd1, 32'd0);
    rd_check(4'd0, 32'h4, "R7");
    wr(4'd0, 32'h0);
    rd_check(4'd0, 32'h4, "R7");
    wr(4'd0, 32'h3);
    rd_check(4'd0, 32'h4, "R7");
    wr(4'd0, 32'h4);
    rd_check(4'd0, 32'h0, "R7");

    // R8: capture with frozen timer, then running, then held level
    cur_req = "R8";
    wr(4'd2, 32'h0ABC);
    @(posedge clk); #1 cap_in = 1'b1;
    repeat (6) @(posedge clk);
    rd_check(4'd11, 32'h0ABC, "R8");
    rd_check(4'd0, 32'h10, "R8");
    wr(4'd0, 32'h10);
    wr(4'd1, 32'd1);
    repeat (8) @(posedge clk);
    rd_check(4'd0, 32'h0, "R8");
    #1 cap_in = 1'b0;
    repeat (4) @(posedge clk);
    #1 cap_in = 1'b1;
    repeat (6) @(posedge clk);
    wr(4'd1, 32'd0);
    rd_check(4'd0, 32'h10, "R8");
    addr = 4'd11; @(negedge clk);
    chk(rdata != 32'h0ABC, "R8", "second capture updated", rdata, 32'h0ABC);

    // R10: reserved bits and unmapped words
    cur_req = "R10";
    wr(4'd6, 32'hDEAD_BEEF);
    rd_check(4'd6, 32'h0000_BEEF, "R10");
    wr(4'd0, 32'hFFFF_FFE0);
    rd_check(4'd0, 32'h10, "R10");
    rd_check(4'd5, 32'd0, "R10");
    rd_check(4'd10, 32'd0, "R10");
    rd_check(4'd15, 32'd0, "R10");

    repeat (3) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule